// File: doc/BRIEF.md
# LIN Transmitter Safety Gate

This block sits between a LIN protocol controller's transmit line and the enable of the bus driver. On every clock it decides whether the driver may pull the bus dominant. The controller's transmit level is first brought into the clock domain by a two-flop synchronizer. Three independent protections can then veto a dominant request. A dominant-timeout counter frees a bus held low by a stuck controller. A thermal lock follows the over-temperature comparator and re-arms only after the transmit line returns high. A battery mute with hysteresis silences the driver on a low supply.

The analog comparators (temperature, battery low and battery high) are outside this block and arrive as digital flags that are already synchronous to the clock. The mode logic supplies a flag that is high in normal operation. Each protection reports its own status output, so that test equipment can see which one is holding the bus recessive. The battery mute only gates the driver. It never changes the mode.

Top module: `lin_tx_guard`

## Requirements
- R1: `drive_dom_o` is high exactly when `normal_mode_i` is high, the synchronized transmit level is low, and `timeout_active_o`, `thermal_lock_o` and `battery_mute_o` are all low. A change on `txd_i` reaches the synchronized level after two clock edges.
- R2: While `normal_mode_i` is low, `drive_dom_o` stays low whatever `txd_i` does.
- R3: Once the synchronized transmit level has been low at `TIMEOUT_CYCLES` consecutive clock edges, `timeout_active_o` goes high and `drive_dom_o` goes low. With `txd_i` falling just after an edge, the output drives for edges 2 to `TIMEOUT_CYCLES`+1 and is recessive from edge `TIMEOUT_CYCLES`+2 on.
- R4: The timeout counter saturates, so a low level held far beyond the window keeps `timeout_active_o` high and never re-enables the driver by wrapping.
- R5: The timeout clears only at a clock edge where the synchronized transmit level is high. It is low three edges after `txd_i` rises, and dominant transmission can then resume.
- R6: At the first clock edge where `overtemp_i` is high, `thermal_lock_o` is set and the driver is released.
- R7: After `overtemp_i` falls, `thermal_lock_o` stays high until an edge at which the synchronized transmit level is high.
- R8: At an edge where `batt_low_i` is high, `battery_mute_o` is set. It then stays set until an edge where `batt_high_i` is high and `batt_low_i` is low. When both flags are high, low wins.
- R9: After a synchronous active-low reset, all outputs are low and the synchronized transmit level is high (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Controller transmit level, low requests dominant (asynchronous) |
| normal_mode_i | input | 1 | High while the transceiver is in normal mode |
| overtemp_i | input | 1 | Over-temperature comparator flag (synchronous) |
| batt_low_i | input | 1 | Battery below the low monitor level (synchronous) |
| batt_high_i | input | 1 | Battery above the high monitor level (synchronous) |
| drive_dom_o | output | 1 | Enable for the bus driver to pull dominant |
| timeout_active_o | output | 1 | Dominant timeout lock is active |
| thermal_lock_o | output | 1 | Thermal lock is active |
| battery_mute_o | output | 1 | Battery monitor mutes the driver |

## Verification
The hardest case to reach from the ports is the exact edge of the dominant window. It has to be hit after the two-cycle synchronizer delay and with a counter that must never wrap. The bench lowers `txd_i` just after an edge and counts edges to sample one cycle before the cutoff and exactly at it. It then holds the line low for several windows to show saturation, and releases it to time the three-edge recovery. The thermal re-arm case also needs care. The bench clears the temperature flag while the line is still low, and it must see the lock persist before the line rises.

// File: rtl/lin_guard_pkg.sv
// Shared types for the LIN transmitter safety gate.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lin_guard_pkg;
    // State of the battery hysteresis monitor.
    typedef enum logic {
        BATT_OK    = 1'b0,
        BATT_MUTED = 1'b1
    } batt_state_t;
endpackage

// File: rtl/lin_bit_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; resets to RESET_VAL synchronously.
module lin_bit_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lin_dom_timer.sv
// Dominant timeout: counts edges with the synchronized line low and
// flags a lock at LIMIT. The count saturates and clears on any high sample.
// Assumes: LIMIT >= 1; txd_s_i is already synchronous.
module lin_dom_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s_i,
    output logic lock_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TERM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count low samples, hold at the terminal count, clear on high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (txd_s_i) begin
            cnt <= '0;
        end else if (cnt != TERM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign lock_o = (cnt == TERM);
endmodule

// File: rtl/lin_thermal_lock.sv
// Thermal lock: sets on over-temperature and re-arms only after the
// flag has cleared and a recessive transmit level is seen.
// Assumes: overtemp_i is synchronous to clk.
module lin_thermal_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic overtemp_i,
    input  logic txd_s_i,
    output logic lock_o
);
    // Set on heat, hold until cool and the line is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o <= 1'b0;
        end else if (overtemp_i) begin
            lock_o <= 1'b1;
        end else if (txd_s_i) begin
            lock_o <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_batt_mon.sv
// Battery monitor with two thresholds: mutes below the low level and
// unmutes only above the high level; the low flag has priority.
// Assumes: both flags are synchronous to clk.
module lin_batt_mon
    import lin_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic high_i,
    output logic mute_o
);
    batt_state_t state;

    // Hysteresis state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BATT_OK;
        end else if (low_i) begin
            state <= BATT_MUTED;
        end else if (high_i) begin
            state <= BATT_OK;
        end
    end

    assign mute_o = (state == BATT_MUTED);
endmodule

// File: rtl/lin_tx_guard.sv
// LIN transmitter safety gate: combines the synchronized transmit level
// with the mode flag and three protection locks into the driver enable.
// Assumes: comparator flags are synchronous; txd_i may be asynchronous.
module lin_tx_guard #(
    parameter int TIMEOUT_CYCLES = 4_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic normal_mode_i,
    input  logic overtemp_i,
    input  logic batt_low_i,
    input  logic batt_high_i,
    output logic drive_dom_o,
    output logic timeout_active_o,
    output logic thermal_lock_o,
    output logic battery_mute_o
);
    logic txd_s;

    lin_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (txd_i),
        .q_o   (txd_s)
    );

    lin_dom_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_s_i (txd_s),
        .lock_o  (timeout_active_o)
    );

    lin_thermal_lock u_thermal (
        .clk        (clk),
        .rst_n      (rst_n),
        .overtemp_i (overtemp_i),
        .txd_s_i    (txd_s),
        .lock_o     (thermal_lock_o)
    );

    lin_batt_mon u_batt (
        .clk    (clk),
        .rst_n  (rst_n),
        .low_i  (batt_low_i),
        .high_i (batt_high_i),
        .mute_o (battery_mute_o)
    );

    // Driver enable: every condition must permit a dominant symbol.
    always_comb begin
        drive_dom_o = normal_mode_i && !txd_s && !timeout_active_o
                      && !thermal_lock_o && !battery_mute_o;
    end
endmodule

// File: rtl/lin_tx_guard_checker.sv
// Temporal checks on the safety gate, bound to every lin_tx_guard.
// Assumes: internal txd_s is reachable through the bind.
module lin_tx_guard_checker (
    input logic clk,
    input logic rst_n,
    input logic txd_s,
    input logic normal_mode_i,
    input logic overtemp_i,
    input logic batt_low_i,
    input logic batt_high_i,
    input logic drive_dom_o,
    input logic timeout_active_o,
    input logic thermal_lock_o,
    input logic battery_mute_o
);
    assert_off_outside_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_mode_i |-> !drive_dom_o);

    assert_timeout_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_active_o |-> !drive_dom_o);

    assert_timeout_holds_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_active_o && !txd_s |=> timeout_active_o);

    assert_timeout_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txd_s |=> !timeout_active_o);

    assert_heat_sets_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp_i |=> thermal_lock_o && !drive_dom_o);

    assert_thermal_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_lock_o && !txd_s |=> thermal_lock_o);

    assert_low_batt_mutes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        batt_low_i |=> battery_mute_o);

    assert_mute_hysteresis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        battery_mute_o && !batt_high_i |=> battery_mute_o);
endmodule

bind lin_tx_guard lin_tx_guard_checker u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .txd_s            (txd_s),
    .normal_mode_i    (normal_mode_i),
    .overtemp_i       (overtemp_i),
    .batt_low_i       (batt_low_i),
    .batt_high_i      (batt_high_i),
    .drive_dom_o      (drive_dom_o),
    .timeout_active_o (timeout_active_o),
    .thermal_lock_o   (thermal_lock_o),
    .battery_mute_o   (battery_mute_o)
);

// File: tb/lin_tx_guard_tb.sv
module lin_tx_guard_tb;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_i = 1'b1;
    logic normal_mode_i = 1'b0;
    logic overtemp_i = 1'b0;
    logic batt_low_i = 1'b0;
    logic batt_high_i = 1'b0;
    logic drive_dom_o, timeout_active_o, thermal_lock_o, battery_mute_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lin_tx_guard #(.TIMEOUT_CYCLES(T)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .txd_i            (txd_i),
        .normal_mode_i    (normal_mode_i),
        .overtemp_i       (overtemp_i),
        .batt_low_i       (batt_low_i),
        .batt_high_i      (batt_high_i),
        .drive_dom_o      (drive_dom_o),
        .timeout_active_o (timeout_active_o),
        .thermal_lock_o   (thermal_lock_o),
        .battery_mute_o   (battery_mute_o)
    );

    // Vector: {normal, txd, overtemp, low, high, exp drive, exp timeout, exp thermal, exp mute, req id}
    typedef struct packed {
        logic n, t, ot, lo, hi, ed, eto, eth, em;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1,1,0,0,0, 0,0,0,0, 4'd1},
        '{1,0,0,0,0, 1,0,0,0, 4'd1},
        '{0,0,0,0,0, 0,0,0,0, 4'd2},
        '{1,1,0,0,0, 0,0,0,0, 4'd1},
        '{1,0,1,0,0, 0,0,1,0, 4'd6},
        '{1,0,0,0,0, 0,0,1,0, 4'd7},
        '{1,1,0,0,0, 0,0,0,0, 4'd7},
        '{1,0,0,0,0, 1,0,0,0, 4'd7},
        '{1,1,0,1,0, 0,0,0,1, 4'd8},
        '{1,0,0,0,0, 0,0,0,1, 4'd8},
        '{1,0,0,0,1, 1,0,0,0, 4'd8},
        '{1,1,0,1,1, 0,0,0,1, 4'd8},
        '{1,1,0,0,1, 0,0,0,0, 4'd8}
    };

    task automatic check(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", what, got, exp);
        end
    endtask

    task automatic check_all(input logic ed, eto, eth, em, input string req);
        check(drive_dom_o, ed, {req, " drive_dom_o"});
        check(timeout_active_o, eto, {req, " timeout_active_o"});
        check(thermal_lock_o, eth, {req, " thermal_lock_o"});
        check(battery_mute_o, em, {req, " battery_mute_o"});
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edges(3);
        // R9: reset state
        check_all(0, 0, 0, 0, "R9");
        rst_n = 1'b1;
        edges(1);

        // Table walk, three edges per vector.
        for (int i = 0; i < NV; i++) begin
            normal_mode_i = VECS[i].n;
            txd_i = VECS[i].t;
            overtemp_i = VECS[i].ot;
            batt_low_i = VECS[i].lo;
            batt_high_i = VECS[i].hi;
            edges(3);
            check_all(VECS[i].ed, VECS[i].eto, VECS[i].eth, VECS[i].em,
                      $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R1: two-edge synchronizer latency
        batt_high_i = 1'b0;
        txd_i = 1'b1;
        edges(3);
        txd_i = 1'b0;
        edges(1);
        check(drive_dom_o, 1'b0, "R1 one edge after fall");
        edges(1);
        check(drive_dom_o, 1'b1, "R1 two edges after fall");

        // R3: boundary of the dominant window (T+1 drives, T+2 locked)
        txd_i = 1'b1;
        edges(3);
        txd_i = 1'b0;
        edges(T + 1);
        check(drive_dom_o, 1'b1, "R3 last dominant edge");
        check(timeout_active_o, 1'b0, "R3 no lock yet");
        edges(1);
        check(drive_dom_o, 1'b0, "R3 forced recessive");
        check(timeout_active_o, 1'b1, "R3 lock set");

        // R4: held far beyond the window, no wrap
        edges(3 * T + 5);
        check(timeout_active_o, 1'b1, "R4 saturated lock");
        check(drive_dom_o, 1'b0, "R4 still recessive");

        // R5: release needs a synchronized high sample
        txd_i = 1'b1;
        edges(2);
        check(timeout_active_o, 1'b1, "R5 before high sample");
        edges(1);
        check(timeout_active_o, 1'b0, "R5 after high sample");
        txd_i = 1'b0;
        edges(2);
        check(drive_dom_o, 1'b1, "R5 transmission resumes");

        // R2: toggling outside normal mode never drives
        txd_i = 1'b1;
        edges(3);
        normal_mode_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            txd_i = k[0];
            edges(1);
            check(drive_dom_o, 1'b0, "R2 outside normal");
        end

        // R6: lock set one edge after heat, even with line high
        normal_mode_i = 1'b1;
        txd_i = 1'b1;
        edges(3);
        overtemp_i = 1'b1;
        edges(1);
        check(thermal_lock_o, 1'b1, "R6 lock after one edge");
        overtemp_i = 1'b0;
        edges(1);
        check(thermal_lock_o, 1'b0, "R7 cleared by high line");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule